// File: doc/BRIEF.md
# Multi-Master SCL Clock Synchronizer

This block produces the serial clock for one master on a two-wire bus whose clock line is a wired-AND shared with other masters. It drives the line only by enabling an open-drain pull-down. It times a programmed low phase and a programmed high phase, and it watches the bus clock level through a synchronizer chain. The line is released when the low phase ends. The high phase is timed only after the line is seen high, so a slower master that holds the line low stretches the low phase. If another master pulls the line low while the high phase is being timed, that phase is abandoned and a new low phase starts at once.

Because each master starts its low phase as soon as any master pulls the line low, and waits for the last master to let go, the shared clock ends up with the shortest high phase and the longest low phase among the participants. A one-cycle tick marks each falling edge that this block produces by completing its own high phase. A data shifter uses the tick to step to the next bit. Deasserting the enable releases the line and discards any count in progress.

Top module: `scl_clock_sync`

## Requirements
- R1: After reset the pull-down output `scl_pull_low` is 0 and `bit_tick` is 0.
- R2: When `enable` is sampled low, `scl_pull_low` and `bit_tick` are 0 from the next cycle on. Any count in progress is discarded, so the next enable starts a full low phase.
- R3: When `enable` is first sampled high while idle, `scl_pull_low` is 1 from the next cycle, and `bit_tick` stays 0 in that cycle.
- R4: Each low phase holds `scl_pull_low` at 1 for exactly `low_cnt` cycles. Legal values of `low_cnt` and `high_cnt` are 2 or more.
- R5: `scl_bus` passes through `SYNC_STAGES` flops, default 2, before use. The high count starts only after the synchronized level is 1. With the default depth, and with the bus following the block's own pull-down, the line is released for exactly `high_cnt + 3` cycles.
- R6: If another master keeps the bus low for X extra cycles after this block releases it, the block stays released and does not count. The release then lasts `X + high_cnt + 3` cycles.
- R7: If the bus goes low during cycle k while the high phase is being timed, `scl_pull_low` is 1 from cycle k+3. This abandonment takes precedence over completing the high count in the same cycle.
- R8: `bit_tick` is 1 for exactly one cycle: the first cycle of a low phase that follows a completed high count. It stays 0 when the low phase was started by enable or by abandonment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the clock generator when 1 |
| low_cnt | input | CNT_W | Low-phase length in cycles (at least 2) |
| high_cnt | input | CNT_W | High-phase length in cycles (at least 2) |
| scl_bus | input | 1 | Bus clock line level, asynchronous |
| scl_pull_low | output | 1 | Open-drain pull-down enable for the clock line |
| bit_tick | output | 1 | One-cycle strobe at a self-produced falling edge |

## Verification
Two events can fall in the same cycle: the high counter reaching its last value, and the synchronized bus level showing that another master has pulled the line low. The bench provokes this by asserting the external pull-down exactly `high_cnt - 3` cycles into the timed high phase, so that the low level reaches the synchronizer output in the high counter's final cycle. The expected result is a release lasting `high_cnt + 3` cycles, as in the uncontested case, but with no `bit_tick` on the following rise. Random low, high, stretch and early-pull offsets from a fixed seed cover the ordinary cases around this one.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } phase_t;
endpackage

// File: rtl/scl_sync_chain.sv
module scl_sync_chain #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("scl_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RESET_VAL;
      else        chain_q[0] <= async_in;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RESET_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             at_last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("scl_phase_counter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (clear)   count <= '0;
      else if (advance) count <= count + ONE;
   end

   assign at_last = (count == (limit - ONE));

   // R4: an advancing count never walks past the programmed last value
   a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && limit >= CNT_W'(2)) |-> (count < limit - ONE));
endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] low_cnt,
   input  logic [CNT_W-1:0] high_cnt,
   input  logic             scl_bus,
   output logic             scl_pull_low,
   output logic             bit_tick
);
   import scl_sync_pkg::*;

   localparam logic [CNT_W-1:0] MIN_PHASE = CNT_W'(2);

   phase_t           ph_q, ph_d;
   logic             scl_s;
   logic             cnt_clear, cnt_adv, cnt_last;
   logic [CNT_W-1:0] cnt_val, cnt_limit;
   logic             tick_d, tick_q;

   scl_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (scl_bus),
      .sync_out (scl_s)
   );

   assign cnt_limit = (ph_q == PH_HIGH) ? high_cnt : low_cnt;

   scl_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (cnt_clear),
      .advance (cnt_adv),
      .limit   (cnt_limit),
      .count   (cnt_val),
      .at_last (cnt_last)
   );

   always_comb begin
      ph_d      = ph_q;
      cnt_clear = 1'b1;
      cnt_adv   = 1'b0;
      tick_d    = 1'b0;
      if (!enable) begin
         ph_d = PH_IDLE;
      end else begin
         unique case (ph_q)
            PH_IDLE: ph_d = PH_LOW;
            PH_LOW: begin
               if (cnt_last) ph_d = PH_WAIT;
               else begin
                  cnt_clear = 1'b0;
                  cnt_adv   = 1'b1;
               end
            end
            PH_WAIT: begin
               if (scl_s) ph_d = PH_HIGH;
            end
            PH_HIGH: begin
               if (!scl_s) begin
                  ph_d = PH_LOW;
               end else if (cnt_last) begin
                  ph_d   = PH_LOW;
                  tick_d = 1'b1;
               end else begin
                  cnt_clear = 1'b0;
                  cnt_adv   = 1'b1;
               end
            end
            default: ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         tick_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         tick_q <= tick_d;
      end
   end

   assign scl_pull_low = (ph_q == PH_LOW);
   assign bit_tick     = tick_q;

   // R4: programmed phase lengths stay legal while running
   a_r4_limits_legal: assert property (@(posedge clk) disable iff (!rst_n)
      enable |-> (low_cnt >= MIN_PHASE && high_cnt >= MIN_PHASE));

   // R2: disabling releases the line and silences the tick
   a_r2_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_pull_low && !bit_tick));

   // R4: an unfinished low phase keeps pulling
   a_r4_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && scl_pull_low && !cnt_last) |=> scl_pull_low);

   // R6: a line held low by another master keeps the block waiting and released
   a_r6_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && ph_q == PH_WAIT && !scl_s) |=> (ph_q == PH_WAIT && !scl_pull_low));

   // R7: a low seen during the high count restarts the low phase without a tick
   a_r7_early_low: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && ph_q == PH_HIGH && !scl_s) |=> (scl_pull_low && !bit_tick));

   // R8: the tick lasts one cycle and lines up with the pull-down
   a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick);
   a_r8_tick_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> scl_pull_low);
endmodule

// File: tb/scl_clock_sync_test.sv
module scl_clock_sync_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [CW-1:0] low_cnt = CW'(4);
   logic [CW-1:0] high_cnt = CW'(4);
   logic          ext_low = 1'b0;
   logic          scl_bus;
   logic          scl_pull_low, bit_tick;
   int            checks = 0;
   int            errors = 0;

   assign scl_bus = ~(scl_pull_low | ext_low);

   scl_clock_sync #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_bus(scl_bus),
      .scl_pull_low(scl_pull_low), .bit_tick(bit_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // expected release length for each mode, from the requirements
   function automatic int exp_release(int mode, int h, int x);
      if (mode == 1) return x + h + 3;   // R6 stretch
      if (mode == 2) return x + 6;       // R7 early pull
      return h + 3;                      // R5 uncontested
   endfunction

   // Called at the negedge of the first cycle of a low phase.
   // mode 0: uncontested, 1: external stretch by x, 2: external early pull x cycles into high count
   task automatic one_period(int l, int h, int mode, int x, bit exp_tick, output bit next_tick);
      int c = 0, lo = 0, rel = 0, extra = 0;
      check(bit_tick === exp_tick, "R8 tick at low start", int'(bit_tick), int'(exp_tick));
      forever begin
         if (mode == 1 && c == 0)         ext_low = 1'b1;
         if (mode == 1 && c == l + x)     ext_low = 1'b0;
         if (mode == 2 && c == l + 3 + x) ext_low = 1'b1;
         if (scl_pull_low) lo++; else rel++;
         cyc();
         c++;
         if (scl_pull_low && rel > 0) break;
         if (c > 4000) break;
         if (bit_tick) extra++;
      end
      if (mode == 2) ext_low = 1'b0;
      check(lo == l, "R4 low length", lo, l);
      check(rel == exp_release(mode, h, x),
            mode == 1 ? "R6 stretched release" : mode == 2 ? "R7 early pull release" : "R5 high release",
            rel, exp_release(mode, h, x));
      check(extra == 0, "R8 stray tick", extra, 0);
      next_tick = (mode != 2);
   endtask

   task automatic start_run(int l, int h);
      enable   = 1'b0;
      cyc();
      low_cnt  = CW'(l);
      high_cnt = CW'(h);
      enable   = 1'b1;
      cyc();
      check(scl_pull_low === 1'b1, "R3 pull after enable", int'(scl_pull_low), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      bit tk;
      void'($urandom(32'h5eed_1234));
      repeat (3) cyc();
      check(scl_pull_low === 1'b0, "R1 reset pull", int'(scl_pull_low), 0);
      check(bit_tick === 1'b0, "R1 reset tick", int'(bit_tick), 0);
      rst_n = 1'b1;
      cyc();
      check(scl_pull_low === 1'b0, "R1 idle pull", int'(scl_pull_low), 0);

      // directed uncontested, minimum lengths
      start_run(2, 2);
      one_period(2, 2, 0, 0, 1'b0, tk);
      one_period(2, 2, 0, 0, tk, tk);

      // directed stretch by one cycle
      start_run(5, 4);
      one_period(5, 4, 1, 1, 1'b0, tk);
      one_period(5, 4, 0, 0, tk, tk);

      // directed early pull at the first high cycle
      start_run(3, 6);
      one_period(3, 6, 2, 0, 1'b0, tk);
      one_period(3, 6, 0, 0, tk, tk);

      // directed same-cycle case: low seen in the last high-count cycle (R7 wins, no tick)
      start_run(4, 7);
      one_period(4, 7, 2, 4, 1'b0, tk);
      one_period(4, 7, 0, 0, tk, tk);
      check(tk === 1'b1, "R8 tick after completed high", int'(tk), 1);

      // R2: disable mid low phase, then a fresh full low phase
      start_run(9, 3);
      cyc(); cyc();
      enable = 1'b0;
      cyc();
      check(scl_pull_low === 1'b0, "R2 release on disable", int'(scl_pull_low), 0);
      for (int i = 0; i < 4; i++) begin
         check(scl_pull_low === 1'b0 && bit_tick === 1'b0, "R2 quiet while disabled",
               int'(scl_pull_low | bit_tick), 0);
         cyc();
      end
      enable = 1'b1;
      cyc();
      check(scl_pull_low === 1'b1, "R3 pull after re-enable", int'(scl_pull_low), 1);
      one_period(9, 3, 0, 0, 1'b0, tk);

      // constrained random runs
      for (int r = 0; r < 40; r++) begin
         int l = 2 + int'($urandom_range(10));
         int h = 3 + int'($urandom_range(9));
         start_run(l, h);
         tk = 1'b0;
         for (int p = 0; p < 5; p++) begin
            int mode = int'($urandom_range(2));
            int x = (mode == 1) ? 1 + int'($urandom_range(8)) :
                    (mode == 2) ? int'($urandom_range(h - 3)) : 0;
            one_period(l, h, mode, x, tk, tk);
         end
      end

      enable = 1'b0;
      cyc();
      check(scl_pull_low === 1'b0, "R2 final release", int'(scl_pull_low), 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule